// File: doc/BRIEF.md
# Programmable BAR Window Decoder

This block decodes a system address against three programmable windows: two memory-mapped I/O windows, each defined by a base register and a mask register, and a register window of fixed size. Software programs the bases, the masks and a group of enable bits through a 64-bit register write port. Every stored value is trimmed to its legal bits first. Reset loads the base values from a chip number and a unit number on two small strap inputs. Reset also loads the mask values and clears all enables.

A separate lookup port takes an address with a valid strobe. One cycle later the block returns a code for the window that was hit and the byte offset into that window. When windows overlap, a fixed priority picks one of them. The block also drives the effective base and size of each window, so the programmed layout can be seen from outside. Two sticky flags record illegal write activity.

Top module: `bar_window_decoder`

## Requirements
- R1: A write takes effect only when `wr_en` is high, `wr_bytes` equals 8 and `wr_addr[2:0]` is zero. The register is chosen by `wr_addr >> 3`: index 0 is the MMIO0 base, 1 is the MMIO1 base, 2 is the MMIO0 mask, 3 is the MMIO1 mask, 4 is the register-window base and 5 is the enable register.
- R2: A write to either MMIO base or either MMIO mask stores only data bits 63..30. Bits 29..0 are stored as zero.
- R3: A write to the register-window base stores only data bits 63..26. Bits 25..0 are stored as zero.
- R4: A write to the enable register keeps data bits 63..59. Bit 63 enables MMIO0, bit 62 enables MMIO1 and bit 61 enables the register window. Each `win_baseN` output equals its stored base register shifted right by 14.
- R5: `win_size0` and `win_size1` equal ((~mask) >> 14) + 1 for their own mask. `win_size2` is always 0x1000.
- R6: After reset, the stored MMIO0 base is (0x3d00000000000 + 0x4000000000·chip + 0x1000000000·unit) << 14. The MMIO1 base is (0x3ff8000000000 + 0x200000000·chip + 0x80000000·unit) << 14. The register-window base is (0x3fffe40000000 + 0x400000·chip + 0x100000·unit) << 14. The masks are 0x3fff000000000 << 14 for MMIO0 and 0x3ffff80000000 << 14 for MMIO1. All enables are clear, both error flags are low and `res_vld` is low.
- R7: A write to a base or mask register whose window is enabled still updates that register, and it also sets the sticky flag `err_live_chg`.
- R8: A write with a bad size, a misaligned address or an unlisted index (6 or 7) changes no register, and it sets the sticky flag `err_bad_wr`.
- R9: A window is hit when it is enabled and base ≤ address < base + size. `res_off` is the address minus the base of the reported window. `res_win` is 0 for no hit, 1 for MMIO0, 2 for MMIO1 and 3 for the register window. With no hit, `res_off` is 0.
- R10: When more than one window is hit, MMIO0 wins over MMIO1, and MMIO1 wins over the register window.
- R11: `res_vld`, `res_win` and `res_off` are registered. `res_vld` is high exactly in the cycle after a cycle with `lk_vld` high, and it carries the result for that lookup address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | CHIP_W | Chip number used to form the reset bases |
| unit_id | input | UNIT_W | Unit number used to form the reset bases |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | RA_W | Byte address of the write |
| wr_bytes | input | 4 | Access size in bytes |
| wr_data | input | 64 | Write data |
| lk_vld | input | 1 | Lookup request strobe |
| lk_addr | input | 64 | Address to decode |
| res_vld | output | 1 | Lookup result valid |
| res_win | output | 2 | Code of the window that was hit |
| res_off | output | 64 | Offset into the window that was hit |
| win_base0 | output | 64 | Effective base of MMIO0 |
| win_size0 | output | 64 | Size of MMIO0 |
| win_base1 | output | 64 | Effective base of MMIO1 |
| win_size1 | output | 64 | Size of MMIO1 |
| win_base2 | output | 64 | Effective base of the register window |
| win_size2 | output | 64 | Size of the register window |
| err_live_chg | output | 1 | Sticky flag: an enabled window was reprogrammed |
| err_bad_wr | output | 1 | Sticky flag: a write was rejected |

## Verification
Lookups are aimed at each window's first byte, its last byte, the byte just past its end and the byte just below its base. These addresses separate the two range compares and catch any off-by-one in the size. Stacking all three windows at one base separates the priority order from the enable gating, and turning the enables off one at a time shows each lower window taking over. Random writes with full 64-bit data exercise the trimming of every register. Rejected writes of every kind are followed by a readback through the base and size outputs, to show that nothing changed.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int SHIFT = 14;
  localparam int NWIN  = 3;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_MM0  = 2'd1,
    WIN_MM1  = 2'd2,
    WIN_REG  = 2'd3
  } win_e;

  localparam logic [63:0] MMIO_KEEP = 64'hFFFF_FFFF_C000_0000;
  localparam logic [63:0] REGW_KEEP = 64'hFFFF_FFFF_FC00_0000;

  localparam logic [63:0] MM0_ORG  = 64'h0003_D000_0000_0000;
  localparam logic [63:0] MM0_CHIP = 64'h0000_0040_0000_0000;
  localparam logic [63:0] MM0_UNIT = 64'h0000_0010_0000_0000;
  localparam logic [63:0] MM1_ORG  = 64'h0003_FF80_0000_0000;
  localparam logic [63:0] MM1_CHIP = 64'h0000_0002_0000_0000;
  localparam logic [63:0] MM1_UNIT = 64'h0000_0000_8000_0000;
  localparam logic [63:0] RGW_ORG  = 64'h0003_FFFE_4000_0000;
  localparam logic [63:0] RGW_CHIP = 64'h0000_0000_0040_0000;
  localparam logic [63:0] RGW_UNIT = 64'h0000_0000_0010_0000;
  localparam logic [63:0] MSK0_RST = 64'h0003_FFF0_0000_0000 << SHIFT;
  localparam logic [63:0] MSK1_RST = 64'h0003_FFFF_8000_0000 << SHIFT;

  localparam logic [63:0] REGW_BYTES = 64'h1000;
endpackage

// File: rtl/bwd_regfile.sv
module bwd_regfile #(
  parameter int CHIP_W = 3,
  parameter int UNIT_W = 3,
  parameter int RA_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CHIP_W-1:0]    chip_id,
  input  logic [UNIT_W-1:0]    unit_id,
  input  logic                 wr_en,
  input  logic [RA_W-1:0]      wr_addr,
  input  logic [3:0]           wr_bytes,
  input  logic [63:0]          wr_data,
  output logic [2:0][63:0]     base_o,
  output logic [1:0][63:0]     mask_o,
  output logic [2:0]           en_o,
  output logic                 err_live_o,
  output logic                 err_bad_o
);
  import bwd_pkg::*;

  localparam int IDX_W = RA_W - 3;

  logic [2:0][63:0] base_q, base_d, dflt;
  logic [1:0][63:0] mask_q, mask_d;
  logic [4:0]       en_q, en_d;
  logic             live_q, live_d, bad_q, bad_d;
  logic             acc_ok;
  logic [IDX_W-1:0] idx;

  assign dflt[0] = (MM0_ORG + MM0_CHIP * 64'(chip_id) + MM0_UNIT * 64'(unit_id)) << SHIFT;
  assign dflt[1] = (MM1_ORG + MM1_CHIP * 64'(chip_id) + MM1_UNIT * 64'(unit_id)) << SHIFT;
  assign dflt[2] = (RGW_ORG + RGW_CHIP * 64'(chip_id) + RGW_UNIT * 64'(unit_id)) << SHIFT;

  assign acc_ok = wr_en && (wr_bytes == 4'd8) && (wr_addr[2:0] == 3'b000);
  assign idx    = wr_addr[RA_W-1:3];

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    en_d   = en_q;
    live_d = live_q;
    bad_d  = bad_q;
    if (wr_en && !acc_ok) begin
      bad_d = 1'b1;
    end else if (acc_ok) begin
      case (idx)
        IDX_W'(0): begin base_d[0] = wr_data & MMIO_KEEP; live_d = live_q | en_q[4]; end
        IDX_W'(1): begin base_d[1] = wr_data & MMIO_KEEP; live_d = live_q | en_q[3]; end
        IDX_W'(2): begin mask_d[0] = wr_data & MMIO_KEEP; live_d = live_q | en_q[4]; end
        IDX_W'(3): begin mask_d[1] = wr_data & MMIO_KEEP; live_d = live_q | en_q[3]; end
        IDX_W'(4): begin base_d[2] = wr_data & REGW_KEEP; live_d = live_q | en_q[2]; end
        IDX_W'(5): en_d = wr_data[63:59];
        default:   bad_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= dflt;
      mask_q <= {MSK1_RST, MSK0_RST};
      en_q   <= '0;
      live_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (wr_en) begin
      base_q <= base_d;
      mask_q <= mask_d;
      en_q   <= en_d;
      live_q <= live_d;
      bad_q  <= bad_d;
    end
  end

  assign base_o     = base_q;
  assign mask_o     = mask_q;
  assign en_o       = {en_q[2], en_q[3], en_q[4]};
  assign err_live_o = live_q;
  assign err_bad_o  = bad_q;

  // R2: an accepted MMIO0 base write stores the trimmed data
  a_r2_mmio_trim: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && idx == IDX_W'(0)) |=> (base_o[0] == ($past(wr_data) & MMIO_KEEP)));
  // R7: the live-change flag never clears once set
  a_r7_live_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_live_o |=> err_live_o);
  // R8: a rejected access raises the bad-write flag
  a_r8_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_ok) |=> err_bad_o);
  // R4: enables move only on an accepted write to index 5
  a_r4_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ok && idx == IDX_W'(5)) |=> $stable(en_o));
endmodule

// File: rtl/bwd_window.sv
module bwd_window #(
  parameter bit FIXED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [63:0] base_reg,
  input  logic [63:0] mask_reg,
  input  logic [63:0] addr,
  output logic [63:0] base,
  output logic [63:0] size,
  output logic        hit,
  output logic [63:0] off
);
  import bwd_pkg::*;

  assign base = base_reg >> SHIFT;

  if (FIXED) begin : g_fixed
    logic unused_mask;
    assign unused_mask = ^mask_reg;
    assign size = REGW_BYTES;
  end else begin : g_mask
    assign size = ((~mask_reg) >> SHIFT) + 64'd1;
  end

  assign hit = en && (addr >= base) && (addr < base + size);
  assign off = addr - base;

  // R9: a hit always lies inside the window
  a_r9_off_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (off < size));
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
  parameter int CHIP_W = 3,
  parameter int UNIT_W = 3,
  parameter int RA_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] chip_id,
  input  logic [UNIT_W-1:0] unit_id,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [3:0]        wr_bytes,
  input  logic [63:0]       wr_data,
  input  logic              lk_vld,
  input  logic [63:0]       lk_addr,
  output logic              res_vld,
  output logic [1:0]        res_win,
  output logic [63:0]       res_off,
  output logic [63:0]       win_base0,
  output logic [63:0]       win_size0,
  output logic [63:0]       win_base1,
  output logic [63:0]       win_size1,
  output logic [63:0]       win_base2,
  output logic [63:0]       win_size2,
  output logic              err_live_chg,
  output logic              err_bad_wr
);
  import bwd_pkg::*;

  logic [2:0][63:0] base_q, base_w, size_w, off_w, mask_all;
  logic [1:0][63:0] mask_q;
  logic [2:0]       en_w, hit_w;

  bwd_regfile #(.CHIP_W(CHIP_W), .UNIT_W(UNIT_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .unit_id(unit_id),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bytes(wr_bytes), .wr_data(wr_data),
    .base_o(base_q), .mask_o(mask_q), .en_o(en_w),
    .err_live_o(err_live_chg), .err_bad_o(err_bad_wr)
  );

  assign mask_all = {64'd0, mask_q[1], mask_q[0]};

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    bwd_window #(.FIXED(g == NWIN - 1)) u_w (
      .clk(clk), .rst_n(rst_n), .en(en_w[g]),
      .base_reg(base_q[g]), .mask_reg(mask_all[g]), .addr(lk_addr),
      .base(base_w[g]), .size(size_w[g]), .hit(hit_w[g]), .off(off_w[g])
    );
  end

  win_e        win_d;
  logic [63:0] off_d;
  logic        vld_d;

  always_comb begin
    win_d = WIN_NONE;
    off_d = '0;
    if (hit_w[0]) begin
      win_d = WIN_MM0; off_d = off_w[0];
    end else if (hit_w[1]) begin
      win_d = WIN_MM1; off_d = off_w[1];
    end else if (hit_w[2]) begin
      win_d = WIN_REG; off_d = off_w[2];
    end
    vld_d = lk_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_win <= WIN_NONE;
      res_off <= '0;
    end else begin
      res_vld <= vld_d;
      if (lk_vld) begin
        res_win <= win_d;
        res_off <= off_d;
      end
    end
  end

  assign win_base0 = base_w[0];
  assign win_size0 = size_w[0];
  assign win_base1 = base_w[1];
  assign win_size1 = size_w[1];
  assign win_base2 = base_w[2];
  assign win_size2 = size_w[2];

  // R11: one result per lookup, one cycle later
  a_r11_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vld |=> res_vld);
  a_r11_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_vld |=> !res_vld);
  // R10: an MMIO0 hit is always the one reported
  a_r10_mm0_first: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld && hit_w[0]) |=> (res_win == WIN_MM0));
endmodule

// File: tb/sim_bar_window_decoder.sv
module sim_bar_window_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] chip_id = 3'd2;
  logic [2:0] unit_id = 3'd1;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [3:0] wr_bytes = '0;
  logic [63:0] wr_data = '0;
  logic lk_vld = 1'b0;
  logic [63:0] lk_addr = '0;
  logic res_vld;
  logic [1:0] res_win;
  logic [63:0] res_off, win_base0, win_size0, win_base1, win_size1, win_base2, win_size2;
  logic err_live_chg, err_bad_wr;

  always #5 clk = ~clk;

  bar_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .unit_id(unit_id),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bytes(wr_bytes), .wr_data(wr_data),
    .lk_vld(lk_vld), .lk_addr(lk_addr), .res_vld(res_vld), .res_win(res_win),
    .res_off(res_off), .win_base0(win_base0), .win_size0(win_size0),
    .win_base1(win_base1), .win_size1(win_size1), .win_base2(win_base2),
    .win_size2(win_size2), .err_live_chg(err_live_chg), .err_bad_wr(err_bad_wr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_base [3];
  logic [63:0] m_mask [2];
  logic [2:0]  m_en;
  logic        m_live, m_bad;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] e_base(input int w);
    return m_base[w] >> 14;
  endfunction

  function automatic logic [63:0] e_size(input int w);
    if (w == 2) return 64'h1000;
    return ((~m_mask[w]) >> 14) + 64'd1;
  endfunction

  task automatic model_reset();
    m_base[0] = (64'h3d00000000000 + 64'h4000000000 * 64'(chip_id) + 64'h1000000000 * 64'(unit_id)) << 14;
    m_base[1] = (64'h3ff8000000000 + 64'h200000000 * 64'(chip_id) + 64'h80000000 * 64'(unit_id)) << 14;
    m_base[2] = (64'h3fffe40000000 + 64'h400000 * 64'(chip_id) + 64'h100000 * 64'(unit_id)) << 14;
    m_mask[0] = 64'h3fff000000000 << 14;
    m_mask[1] = 64'h3ffff80000000 << 14;
    m_en = '0; m_live = 1'b0; m_bad = 1'b0;
  endtask

  task automatic check_state(input string req);
    chk({req, " base0"}, win_base0, e_base(0));
    chk({req, " size0"}, win_size0, e_size(0));
    chk({req, " base1"}, win_base1, e_base(1));
    chk({req, " size1"}, win_size1, e_size(1));
    chk({req, " base2"}, win_base2, e_base(2));
    chk({req, " size2"}, win_size2, e_size(2));
    chk({req, " R7 live flag"}, 64'(err_live_chg), 64'(m_live));
    chk({req, " R8 bad flag"}, 64'(err_bad_wr), 64'(m_bad));
  endtask

  // R1..R8 model of one write
  task automatic do_write(input logic [5:0] a, input logic [3:0] nb, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_bytes = nb; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (nb != 4'd8 || a[2:0] != 3'b0) m_bad = 1'b1;
    else case (a[5:3])
      3'd0: begin m_base[0] = d & 64'hFFFFFFFFC0000000; m_live |= m_en[0]; end
      3'd1: begin m_base[1] = d & 64'hFFFFFFFFC0000000; m_live |= m_en[1]; end
      3'd2: begin m_mask[0] = d & 64'hFFFFFFFFC0000000; m_live |= m_en[0]; end
      3'd3: begin m_mask[1] = d & 64'hFFFFFFFFC0000000; m_live |= m_en[1]; end
      3'd4: begin m_base[2] = d & 64'hFFFFFFFFFC000000; m_live |= m_en[2]; end
      3'd5: m_en = {d[61], d[62], d[63]};
      default: m_bad = 1'b1;
    endcase
  endtask

  // R9/R10 model
  task automatic do_lookup(input logic [63:0] a, input string req);
    logic [1:0] ew;
    logic [63:0] eo;
    ew = 2'd0; eo = '0;
    for (int w = 0; w < 3; w++) begin
      if (ew == 2'd0 && m_en[w] && a >= e_base(w) && a < e_base(w) + e_size(w)) begin
        ew = 2'(w + 1); eo = a - e_base(w);
      end
    end
    @(negedge clk);
    lk_vld = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_vld = 1'b0;
    chk({req, " R11 res_vld"}, 64'(res_vld), 64'd1);
    chk({req, " R9 res_win"}, 64'(res_win), 64'(ew));
    chk({req, " R9 res_off"}, res_off, eo);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check_state("R6 reset");
    chk("R6 res_vld idle", 64'(res_vld), 64'd0);

    // R2 trim on MMIO base and mask, R3 trim on register window
    do_write(6'd0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    check_state("R2 base0 trim");
    do_write(6'd24, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    check_state("R2 mask1 trim");
    do_write(6'd32, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    check_state("R3 regw trim");

    // R8 rejected writes leave state unchanged
    do_write(6'd48, 4'd8, 64'h1234_5678_9ABC_DEF0);
    check_state("R8 index6");
    model_reset(); m_bad = 1'b0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    do_write(6'd0, 4'd4, 64'h0);
    check_state("R8 short size");
    do_write(6'd12, 4'd8, 64'h0);
    check_state("R1 misaligned");

    // R9 boundary lookups with MMIO0 only enabled
    do_write(6'd40, 4'd8, 64'h8000_0000_0000_0000);
    check_state("R4 enable0");
    do_lookup(e_base(0), "R9 first byte");
    do_lookup(e_base(0) + e_size(0) - 1, "R9 last byte");
    do_lookup(e_base(0) + e_size(0), "R9 past end");
    do_lookup(e_base(0) - 1, "R9 below base");
    // R4 enable bits below 61 do nothing
    do_write(6'd40, 4'd8, 64'h1FFF_FFFF_FFFF_FFFF);
    do_lookup(e_base(0), "R4 low bits ignored");
    @(negedge clk);
    chk("R11 no lookup no valid", 64'(res_vld), 64'd0);

    // R7 write to an enabled window
    do_write(6'd40, 4'd8, 64'hE000_0000_0000_0000);
    do_write(6'd8, 4'd8, 64'h0000_4000_0000_0000);
    check_state("R7 live change");

    // R10 overlap: all windows at one base
    do_write(6'd0, 4'd8, 64'h0000_4000_0000_0000);
    do_write(6'd32, 4'd8, 64'h0000_4000_0000_0000);
    do_lookup(e_base(0) + 64'h10, "R10 all three");
    do_write(6'd40, 4'd8, 64'h6000_0000_0000_0000);
    do_lookup(e_base(0) + 64'h10, "R10 mmio1 over regw");
    do_write(6'd40, 4'd8, 64'h2000_0000_0000_0000);
    do_lookup(e_base(0) + 64'hFFF, "R10 regw last");
    do_lookup(e_base(0) + 64'h1000, "R5 regw past end");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [5:0] a;
      logic [3:0] nb;
      a  = 6'({$urandom_range(0, 7), 3'b000});
      nb = ($urandom_range(0, 9) == 0) ? 4'd4 : 4'd8;
      if ($urandom_range(0, 15) == 0) a[1:0] = 2'b10;
      do_write(a, nb, {$urandom, $urandom});
      check_state("R1 random write");
      for (int j = 0; j < 3; j++) begin
        int w;
        logic [63:0] o;
        w = $urandom_range(0, 2);
        case ($urandom_range(0, 4))
          0: o = 64'd0;
          1: o = e_size(w) - 1;
          2: o = e_size(w);
          3: o = 64'hFFFF_FFFF_FFFF_FFFF;
          default: o = {$urandom, $urandom} % e_size(w);
        endcase
        do_lookup(e_base(w) + o, "R9 random lookup");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule